// File: doc/BRIEF.md
# Interrupt Priority Arbiter

This block chooses, for a single target context, which interrupt source should be presented next. Each source has a pending bit, an enable bit, a claimed bit and a four-bit priority. A source takes part only when it is pending, enabled and not already claimed. Among the sources that take part, the one with the highest priority wins. When several share that priority, the smallest identifier wins. Identifier 0 is reserved to mean "nothing selected". Identifiers at or above the configured source count are never picked, so the input vectors can be wider than the live source count.

The selection is a balanced comparison tree built from a parameter. Its result is captured in one output register, so the identifier, the valid flag and the request line all describe the inputs sampled at the previous rising clock edge. The request line is raised only when a winner exists and its priority is strictly above the context threshold. The surrounding controller owns register access, level tracking and claim/complete state. It feeds this block the vectors and uses the identifier as the value a claim returns.

Top module: `irq_prio_arb`

## Requirements
- R1: While `rst_n` is low, `win_id_o`, `win_vld_o` and `win_irq_o` are all 0. The reset is asynchronous.
- R2: The outputs change only at a rising clock edge. After each edge they reflect the inputs present just before that edge, so there is one cycle of latency.
- R3: Source i is a candidate when `pend_i[i]` and `enab_i[i]` are 1 and `claim_i[i]` is 0. When there is no candidate, `win_id_o` is 0 and `win_vld_o` is 0. Otherwise `win_vld_o` is 1 and `win_id_o` names a candidate.
- R4: Source 0 is never selected, whatever its bits and priority.
- R5: The selected source has the highest priority among all candidates. The priority of source i is `prio_i[4*i+3:4*i]`, unsigned, with a range of 0 to 15.
- R6: When several candidates share the highest priority, the one with the smallest identifier is selected.
- R7: A source whose identifier is at or above `NUM_SRC` (default 24) is never selected, even when its bits are set.
- R8: `win_irq_o` is 1 exactly when a winner exists and its priority is strictly greater than `thresh_i`. A priority equal to the threshold does not raise it.
- R9: When the only candidate has priority 0, it is still reported through `win_id_o` with `win_vld_o` at 1, but `win_irq_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | VEC_W (32) | Pending bit per source |
| enab_i | input | VEC_W (32) | Enable bit per source for this context |
| claim_i | input | VEC_W (32) | Claimed (in service) bit per source |
| prio_i | input | 4*VEC_W (128) | Packed four-bit priority per source; source i sits at bits 4*i+3..4*i |
| thresh_i | input | 4 | Context priority threshold |
| win_id_o | output | $clog2(VEC_W) (5) | Selected source identifier; 0 when there is none |
| win_vld_o | output | 1 | A candidate was selected |
| win_irq_o | output | 1 | Selected priority is above the threshold |

## Verification
Two rules can act on the same winner in the same cycle: the lowest-identifier tie break and the exclusion of claimed or disabled sources. The bench provokes this with two equal-priority pending sources and then claims the lower one, which must hand the win to the higher identifier. The threshold comparison is judged in the same patterns. The tie case sets the threshold equal to the winning priority, so a correct identifier must come with the request line low. A random sweep is judged against a bench-side linear scan that replaces the best source only on a strictly greater priority.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int PRIO_W = 4;

  typedef logic [PRIO_W-1:0] prio_t;

  // The challenger (higher identifiers) displaces the holder only on a
  // strictly greater priority; an empty holder always yields.
  function automatic logic takes_over(input logic hold_v, input prio_t hold_p,
                                      input logic chal_v, input prio_t chal_p);
    return chal_v && (!hold_v || (chal_p > hold_p));
  endfunction

  // Request line rule: a winner must exist and lie strictly above threshold.
  function automatic logic above_thr(input logic v, input prio_t p, input prio_t t);
    return v && (p > t);
  endfunction

endpackage

// File: rtl/irq_arb_cand.sv
module irq_arb_cand #(
  parameter int VEC_W   = 32,
  parameter int NUM_SRC = 24
) (
  input  logic [VEC_W-1:0] pend_i,
  input  logic [VEC_W-1:0] enab_i,
  input  logic [VEC_W-1:0] claim_i,
  output logic [VEC_W-1:0] cand_o
);

  for (genvar i = 0; i < VEC_W; i++) begin : g_src
    if (i == 0 || i >= NUM_SRC) begin : g_dead
      assign cand_o[i] = 1'b0;
    end else begin : g_live
      assign cand_o[i] = pend_i[i] & enab_i[i] & ~claim_i[i];
    end
  end

endmodule

// File: rtl/irq_arb_tree.sv
module irq_arb_tree
  import irq_arb_pkg::*;
#(
  parameter int VEC_W = 32,
  localparam int IDW    = $clog2(VEC_W),
  localparam int LEAVES = 1 << IDW,
  localparam int NODES  = 2 * LEAVES - 1
) (
  input  logic [VEC_W-1:0]        cand_i,
  input  logic [PRIO_W*VEC_W-1:0] prio_i,
  output logic                    best_vld_o,
  output logic [IDW-1:0]          best_id_o,
  output prio_t                   best_prio_o
);

  logic           nd_v [NODES];
  prio_t          nd_p [NODES];
  logic [IDW-1:0] nd_i [NODES];

  // Heap layout: node k has children 2k+1 (lower ids) and 2k+2 (higher ids).
  always_comb begin
    for (int l = 0; l < LEAVES; l++) begin
      if (l < VEC_W) begin
        nd_v[LEAVES-1+l] = cand_i[l];
        nd_p[LEAVES-1+l] = prio_i[l*PRIO_W +: PRIO_W];
      end else begin
        nd_v[LEAVES-1+l] = 1'b0;
        nd_p[LEAVES-1+l] = '0;
      end
      nd_i[LEAVES-1+l] = IDW'(l);
    end
    for (int k = LEAVES - 2; k >= 0; k--) begin
      if (takes_over(nd_v[2*k+1], nd_p[2*k+1], nd_v[2*k+2], nd_p[2*k+2])) begin
        nd_v[k] = nd_v[2*k+2];
        nd_p[k] = nd_p[2*k+2];
        nd_i[k] = nd_i[2*k+2];
      end else begin
        nd_v[k] = nd_v[2*k+1];
        nd_p[k] = nd_p[2*k+1];
        nd_i[k] = nd_i[2*k+1];
      end
    end
  end

  assign best_vld_o  = nd_v[0];
  assign best_id_o   = nd_v[0] ? nd_i[0] : '0;
  assign best_prio_o = nd_v[0] ? nd_p[0] : '0;

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int VEC_W   = 32,
  parameter int NUM_SRC = 24,
  localparam int IDW    = $clog2(VEC_W)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [VEC_W-1:0]        pend_i,
  input  logic [VEC_W-1:0]        enab_i,
  input  logic [VEC_W-1:0]        claim_i,
  input  logic [PRIO_W*VEC_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]       thresh_i,
  output logic [IDW-1:0]          win_id_o,
  output logic                    win_vld_o,
  output logic                    win_irq_o
);

  logic [VEC_W-1:0] cand_vec;
  logic             sel_vld;
  logic [IDW-1:0]   sel_id;
  prio_t            sel_prio;
  logic             sel_irq;
  prio_t            win_prio_q;

  irq_arb_cand #(.VEC_W(VEC_W), .NUM_SRC(NUM_SRC)) u_cand (
    .pend_i  (pend_i),
    .enab_i  (enab_i),
    .claim_i (claim_i),
    .cand_o  (cand_vec)
  );

  irq_arb_tree #(.VEC_W(VEC_W)) u_tree (
    .cand_i      (cand_vec),
    .prio_i      (prio_i),
    .best_vld_o  (sel_vld),
    .best_id_o   (sel_id),
    .best_prio_o (sel_prio)
  );

  assign sel_irq = above_thr(sel_vld, sel_prio, thresh_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_id_o   <= '0;
      win_vld_o  <= 1'b0;
      win_irq_o  <= 1'b0;
      win_prio_q <= '0;
    end else begin
      win_id_o   <= sel_id;
      win_vld_o  <= sel_vld;
      win_irq_o  <= sel_irq;
      win_prio_q <= sel_prio;
    end
  end

endmodule

// File: rtl/irq_prio_arb_chk.sv
module irq_prio_arb_chk
  import irq_arb_pkg::*;
#(
  parameter int VEC_W   = 32,
  parameter int NUM_SRC = 24,
  localparam int IDW    = $clog2(VEC_W)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [VEC_W-1:0] cand_vec,
  input prio_t            thresh_i,
  input logic [IDW-1:0]   win_id_o,
  input logic             win_vld_o,
  input logic             win_irq_o,
  input prio_t            win_prio_q
);

  // R4
  id_zero_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld_o |-> (win_id_o != '0));

  // R3
  empty_means_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_vld_o |-> (win_id_o == '0) && !win_irq_o);

  // R3
  winner_was_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld_o |-> |(($past(cand_vec) >> win_id_o) & {{(VEC_W-1){1'b0}}, 1'b1}));

  // R7
  id_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld_o |-> (int'(win_id_o) < NUM_SRC));

  // R8
  irq_above_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_irq_o |-> win_vld_o && (win_prio_q > $past(thresh_i)));

  // R9
  zero_prio_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_prio_q == '0) |-> !win_irq_o);

endmodule

bind irq_prio_arb irq_prio_arb_chk #(.VEC_W(VEC_W), .NUM_SRC(NUM_SRC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cand_vec   (cand_vec),
  .thresh_i   (thresh_i),
  .win_id_o   (win_id_o),
  .win_vld_o  (win_vld_o),
  .win_irq_o  (win_irq_o),
  .win_prio_q (win_prio_q)
);

// File: tb/irq_prio_arb_bench.sv
module irq_prio_arb_bench;

  localparam int VW = 32;
  localparam int NS = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   pend = '0, enab = '0, clm = '0;
  logic [127:0]  prio = '0;
  logic [3:0]    thr = '0;
  logic [4:0]    w_id;
  logic          w_vld, w_irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  logic [4:0] prev_id  = '0;
  logic       prev_vld = 1'b0;
  logic       prev_irq = 1'b0;

  always #10 clk = ~clk;

  irq_prio_arb #(.VEC_W(VW), .NUM_SRC(NS)) u_irq_prio_arb (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .enab_i(enab), .claim_i(clm),
    .prio_i(prio), .thresh_i(thr),
    .win_id_o(w_id), .win_vld_o(w_vld), .win_irq_o(w_irq)
  );

  typedef struct packed {
    logic [31:0]  pend;
    logic [31:0]  en;
    logic [31:0]  clm;
    logic [127:0] prio;
    logic [3:0]   thr;
    logic [4:0]   id;
    logic         vld;
    logic         irq;
  } vec_t;

  localparam int NT = 9;
  localparam vec_t TBL [NT] = '{
    // nothing pending
    '{32'h0, 32'hFFFF_FFFF, 32'h0, 128'h0, 4'd0, 5'd0, 1'b0, 1'b0},
    // single source 5 at prio 3, threshold 2
    '{32'h20, 32'hFFFF_FFFF, 32'h0, (128'h3 << 20), 4'd2, 5'd5, 1'b1, 1'b1},
    // tie 3 vs 9 at prio 7, threshold equal to 7
    '{32'h208, 32'hFFFF_FFFF, 32'h0, (128'h7 << 12) | (128'h7 << 36), 4'd7, 5'd3, 1'b1, 1'b0},
    // same tie, source 3 claimed
    '{32'h208, 32'hFFFF_FFFF, 32'h8, (128'h7 << 12) | (128'h7 << 36), 4'd0, 5'd9, 1'b1, 1'b1},
    // source 2 prio 15 disabled, source 4 prio 1 enabled
    '{32'h14, 32'h10, 32'h0, (128'hF << 8) | (128'h1 << 16), 4'd0, 5'd4, 1'b1, 1'b1},
    // source 1 prio 2 vs source 2 prio 9
    '{32'h6, 32'hFFFF_FFFF, 32'h0, (128'h2 << 4) | (128'h9 << 8), 4'd8, 5'd2, 1'b1, 1'b1},
    // source 28 (beyond NUM_SRC) prio 15 vs source 6 prio 1
    '{32'h1000_0040, 32'hFFFF_FFFF, 32'h0, (128'hF << 112) | (128'h1 << 24), 4'd0, 5'd6, 1'b1, 1'b1},
    // only source 0, prio 15
    '{32'h1, 32'hFFFF_FFFF, 32'h0, 128'hF, 4'd0, 5'd0, 1'b0, 1'b0},
    // only source 7 at prio 0
    '{32'h80, 32'hFFFF_FFFF, 32'h0, 128'h0, 4'd0, 5'd7, 1'b1, 1'b0}
  };

  function automatic string tag_of(input int k);
    case (k)
      0: return "R3";
      1: return "R5";
      2: return "R6";
      3: return "R6";
      4: return "R3";
      5: return "R5";
      6: return "R7";
      7: return "R4";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input logic [4:0] eid, input logic evld,
                     input logic eirq);
    n_chk++;
    if (w_id !== eid || w_vld !== evld || w_irq !== eirq) begin
      n_err++;
      $display("FAIL %s id=%0d vld=%0d irq=%0d expected id=%0d vld=%0d irq=%0d",
               req, w_id, w_vld, w_irq, eid, evld, eirq);
    end
  endtask

  // Independent linear scan of the selection rules.
  task automatic ref_arb(input logic [31:0] p, input logic [31:0] e,
                         input logic [31:0] c, input logic [127:0] pr,
                         input logic [3:0] t, output logic [4:0] id,
                         output logic vld, output logic irq);
    logic [3:0] bp;
    id = '0; vld = 1'b0; bp = '0;
    for (int s = 1; s < NS; s++) begin
      if (p[s] && e[s] && !c[s]) begin
        if (!vld || pr[4*s +: 4] > bp) begin
          vld = 1'b1; id = 5'(s); bp = pr[4*s +: 4];
        end
      end
    end
    irq = vld && (bp > t);
  endtask

  task automatic drive(input logic [31:0] p, input logic [31:0] e,
                       input logic [31:0] c, input logic [127:0] pr,
                       input logic [3:0] t);
    @(negedge clk);
    pend = p; enab = e; clm = c; prio = pr; thr = t;
  endtask

  initial begin
    logic [4:0] rid;
    logic rv, ri;
    logic [31:0] rp, re, rc;
    logic [127:0] rpr;
    logic [3:0] rt;

    // R1: outputs are 0 during reset even with a candidate present
    pend = 32'h20; enab = 32'hFFFF_FFFF; prio = 128'hF << 20;
    repeat (3) @(negedge clk);
    chk("R1", 5'd0, 1'b0, 1'b0);
    pend = '0; prio = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3", 5'd0, 1'b0, 1'b0);

    // Table walk; R2 checked just after each drive, before the edge
    for (int k = 0; k < NT; k++) begin
      drive(TBL[k].pend, TBL[k].en, TBL[k].clm, TBL[k].prio, TBL[k].thr);
      #1;
      chk("R2", prev_id, prev_vld, prev_irq);
      @(negedge clk);
      chk(tag_of(k), TBL[k].id, TBL[k].vld, TBL[k].irq);
      prev_id = TBL[k].id; prev_vld = TBL[k].vld; prev_irq = TBL[k].irq;
    end

    // Random sweep against the scan (R5, R6, R8)
    for (int n = 0; n < 300; n++) begin
      rp  = $urandom;
      re  = $urandom | $urandom;
      rc  = $urandom & $urandom & $urandom;
      rpr = {$urandom, $urandom, $urandom, $urandom};
      if (n % 4 == 0) rpr = rpr & {32{4'h3}};
      rt  = 4'($urandom);
      ref_arb(rp, re, rc, rpr, rt, rid, rv, ri);
      drive(rp, re, rc, rpr, rt);
      @(negedge clk);
      chk("R5", rid, rv, ri);
    end

    // R8: threshold exactly one below the winner raises the request
    drive(32'h100, 32'hFFFF_FFFF, 32'h0, 128'h6 << 32, 4'd5);
    @(negedge clk);
    chk("R8", 5'd8, 1'b1, 1'b1);

    // R1: asynchronous reset clears outputs between edges
    @(posedge clk);
    #3;
    rst_n = 1'b0;
    #1;
    chk("R1", 5'd0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", 5'd8, 1'b1, 1'b1);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule